// File: doc/BRIEF.md
# Parallel Target Configuration Loader

This block is a hardware master that loads a configuration image into a downstream programmable device through its byte-wide slave parallel configuration port. A one-cycle `go` pulse starts a run. The loader first pulses the target's active-low reset line and waits for the target's active-low initialisation status to assert and then release. It then selects the target and enables writes. It takes configuration bytes from a valid/ready stream and presents each one on an 8-bit bus under a configuration clock that it generates itself.

Before each byte the loader checks the target's status inputs. It stops early and without error when the target reports completion. It aborts when the initialisation line drops, which usually means a CRC failure inside the target. After the stream it releases the select line and then the write enable, and it waits for completion and initialisation to both read high. Every wait has its own timeout, counted in system clocks. Each failure leaves a distinct code on `fail_code`. The asynchronous status inputs pass through two-flop synchronisers before the state machine uses them.

States: `S_IDLE`, `S_PULSE` (reset line low for a minimum time), `S_INIT_LO` (reset still low, waiting for INIT to assert), `S_INIT_HI` (reset released, waiting for INIT to release), `S_BYTE` (waiting for a byte, clock high), `S_CCLK_LO`, `S_CCLK_HI`, `S_BUSY` (waiting for BUSY to drop), `S_CLOSE` (select released, write still enabled) and `S_FINAL` (waiting for completion).

Transitions:
- IDLE to PULSE on `go`.
- PULSE to INIT_LO after `PROG_CYC` cycles.
- INIT_LO to INIT_HI when INIT is seen low.
- INIT_HI to BYTE when INIT is seen high.
- BYTE to CCLK_LO on a handshake.
- BYTE to CLOSE when no bytes remain or DONE is seen high.
- CCLK_LO to CCLK_HI, and CCLK_HI to BUSY (or back to BYTE when busy checking is off), each after `PHASE_CYC` cycles.
- BUSY to BYTE when BUSY is seen low.
- CLOSE to FINAL after one cycle.
- FINAL to IDLE on success.
- Any wait to IDLE on a fault or a timeout.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A `go` pulse in idle starts a run, clears `load_ok`, `load_fail` and `fail_code`, and latches `load_len` as the number of bytes to send. A `go` pulse while a run is in progress has no effect.
- R2: The run drives `tgt_reset_n` low for at least `PROG_CYC` cycles. It keeps it low until the synchronised `tgt_init_n` reads low. If that does not happen within `INIT_TMO` cycles of waiting, the run fails with code 1.
- R3: After `tgt_reset_n` is released, no byte is offered until the synchronised `tgt_init_n` reads high. If it stays low for `INIT_TMO` cycles, the run fails with code 2.
- R4: `tgt_sel_n` and `tgt_wen_n` go low together when the byte phase begins and stay low through the last byte. `tgt_sel_n` is never low while `tgt_wen_n` is high.
- R5: For each byte, the byte is placed on `tgt_d` first. `tgt_cclk` is then low for `PHASE_CYC` cycles and high for `PHASE_CYC` cycles. `tgt_d` is stable through the low phase and at the rising edge.
- R6: `s_ready` is high only while the loader waits for a byte with `tgt_cclk` high. Bytes must remain, synchronised DONE must be low and synchronised INIT must be high. Exactly one byte is taken per cycle in which `s_valid` and `s_ready` are both high.
- R7: If DONE reads high before a byte, streaming stops and the run goes to the closing phase with no error, even if bytes remain.
- R8: If `tgt_init_n` reads low before a byte, the run fails with code 3.
- R9: With `BUSY_CHECK`=1, after each byte the loader waits for `tgt_busy` to read low before offering the next byte. If `tgt_busy` stays high for `BUSY_TMO` cycles, the run fails with code 4.
- R10: After the stream, `tgt_sel_n` goes high one cycle before `tgt_wen_n`. The loader then waits for DONE high and INIT released together, which sets `load_ok`. If they do not both appear within `DONE_TMO` cycles, the run fails with code 5. A length of zero goes straight to the closing phase.
- R11: `tgt_init_n`, `tgt_done` and `tgt_busy` each pass through two flops. A change on one of them affects the outputs no earlier than two clock edges later.
- R12: On failure, the loader releases `tgt_reset_n`, `tgt_sel_n` and `tgt_wen_n` (all high) and returns to idle. It sets `load_fail` and holds `fail_code` until the next `go`. `load_ok` and `load_fail` are never both high, and `fail_code` is 0 unless `load_fail` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, honoured in idle only |
| load_len | input | CNT_W | Number of configuration bytes for this run |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Loader accepts the stream byte this cycle |
| tgt_reset_n | output | 1 | Active-low reset/program line to the target |
| tgt_sel_n | output | 1 | Active-low chip select to the target |
| tgt_wen_n | output | 1 | Active-low write enable to the target |
| tgt_cclk | output | 1 | Configuration clock, target latches on its rising edge |
| tgt_d | output | 8 | Configuration data bus |
| tgt_init_n | input | 1 | Asynchronous active-low initialisation/error status from the target |
| tgt_done | input | 1 | Asynchronous completion status from the target |
| tgt_busy | input | 1 | Asynchronous busy status from the target |
| load_ok | output | 1 | Last run completed successfully |
| load_fail | output | 1 | Last run failed |
| fail_code | output | 3 | 0 none, 1 INIT never asserted, 2 INIT never released, 3 INIT dropped during data, 4 BUSY timeout, 5 completion timeout |

## Verification
All target-facing lines and `s_ready` are decoded straight from the state register. A wrong state therefore shows on `tgt_reset_n`, `tgt_sel_n`, `tgt_wen_n`, `tgt_cclk` or `s_ready` in the very cycle after the faulty transition. A miscounted timer shows as a phase or timeout that is one or more cycles too short or too long. A wrong byte counter or early-exit decision shows as a captured byte count at the emulated target that differs from the expected count. A missing or extra synchroniser stage shifts every status reaction by a cycle, and the per-cycle comparison against the behavioural model catches this at the first status change.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PULSE,
        S_INIT_LO,
        S_INIT_HI,
        S_BYTE,
        S_CCLK_LO,
        S_CCLK_HI,
        S_BUSY,
        S_CLOSE,
        S_FINAL
    } ld_state_t;

    typedef enum logic [2:0] {
        FC_NONE         = 3'd0,
        FC_NO_INIT_LOW  = 3'd1,
        FC_NO_INIT_HIGH = 3'd2,
        FC_DATA_INIT    = 3'd3,
        FC_BUSY_TMO     = 3'd4,
        FC_DONE_TMO     = 3'd5
    } fail_code_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 100ps;

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] q
);
    timeunit 1ns;
    timeprecision 100ps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (clr)      q <= '0;
        else if (q != '1)  q <= q + 1'b1;
    end
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int PROG_CYC   = 60,
    parameter int PHASE_CYC  = 2,
    parameter int INIT_TMO   = 100_000_000,
    parameter int BUSY_TMO   = 1_000_000,
    parameter int DONE_TMO   = 40_000_000,
    parameter bit BUSY_CHECK = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] load_len,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    output logic             s_ready,
    output logic             tgt_reset_n,
    output logic             tgt_sel_n,
    output logic             tgt_wen_n,
    output logic             tgt_cclk,
    output logic [7:0]       tgt_d,
    input  logic             tgt_init_n,
    input  logic             tgt_done,
    input  logic             tgt_busy,
    output logic             load_ok,
    output logic             load_fail,
    output logic [2:0]       fail_code
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int LIM_MAX = max2(max2(max2(PROG_CYC, PHASE_CYC), max2(INIT_TMO, BUSY_TMO)), DONE_TMO);
    localparam int TMR_W   = $clog2(LIM_MAX) + 1;
    localparam logic [TMR_W-1:0] PROG_END  = TMR_W'(PROG_CYC - 1);
    localparam logic [TMR_W-1:0] PHASE_END = TMR_W'(PHASE_CYC - 1);
    localparam logic [TMR_W-1:0] INIT_END  = TMR_W'(INIT_TMO - 1);
    localparam logic [TMR_W-1:0] BUSY_END  = TMR_W'(BUSY_TMO - 1);
    localparam logic [TMR_W-1:0] DONE_END  = TMR_W'(DONE_TMO - 1);

    ld_state_t        st, st_nx;
    logic [TMR_W-1:0] tmr;
    logic [2:0]       sync_q;
    logic             init_up, done_s, busy_s;
    logic [CNT_W-1:0] rem;
    logic [7:0]       dreg;
    logic             take, fail_set, ok_set, ready_c;
    fail_code_t       fail_val, code_q;
    logic             ok_q, fail_q;

    // status inputs: bit 0 INIT (high = released), bit 1 DONE, bit 2 BUSY (R11)
    cfgld_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tgt_busy, tgt_done, tgt_init_n}),
        .q     (sync_q)
    );
    assign init_up = sync_q[0];
    assign done_s  = sync_q[1];
    assign busy_s  = sync_q[2];

    // one shared phase/timeout counter, cleared on every state change
    cfgld_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_nx != st),
        .q     (tmr)
    );

    assign ready_c = (st == S_BYTE) && (rem != '0) && !done_s && init_up;
    assign take    = ready_c && s_valid;
    assign s_ready = ready_c;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state and run verdicts
    always_comb begin
        st_nx    = st;
        fail_set = 1'b0;
        fail_val = FC_NONE;
        ok_set   = 1'b0;
        unique case (st)
            S_IDLE:    if (go) st_nx = S_PULSE;
            S_PULSE:   if (tmr == PROG_END) st_nx = S_INIT_LO;
            S_INIT_LO: begin
                if (!init_up) st_nx = S_INIT_HI;
                else if (tmr == INIT_END) begin
                    st_nx = S_IDLE; fail_set = 1'b1; fail_val = FC_NO_INIT_LOW;
                end
            end
            S_INIT_HI: begin
                if (init_up) st_nx = S_BYTE;
                else if (tmr == INIT_END) begin
                    st_nx = S_IDLE; fail_set = 1'b1; fail_val = FC_NO_INIT_HIGH;
                end
            end
            S_BYTE: begin
                if ((rem == '0) || done_s) st_nx = S_CLOSE;
                else if (!init_up) begin
                    st_nx = S_IDLE; fail_set = 1'b1; fail_val = FC_DATA_INIT;
                end
                else if (s_valid) st_nx = S_CCLK_LO;
            end
            S_CCLK_LO: if (tmr == PHASE_END) st_nx = S_CCLK_HI;
            S_CCLK_HI: if (tmr == PHASE_END) st_nx = BUSY_CHECK ? S_BUSY : S_BYTE;
            S_BUSY: begin
                if (!busy_s) st_nx = S_BYTE;
                else if (tmr == BUSY_END) begin
                    st_nx = S_IDLE; fail_set = 1'b1; fail_val = FC_BUSY_TMO;
                end
            end
            S_CLOSE:   st_nx = S_FINAL;
            S_FINAL: begin
                if (done_s && init_up) begin
                    st_nx = S_IDLE; ok_set = 1'b1;
                end
                else if (tmr == DONE_END) begin
                    st_nx = S_IDLE; fail_set = 1'b1; fail_val = FC_DONE_TMO;
                end
            end
            default:   st_nx = S_IDLE;
        endcase
    end

    // target-facing lines, decoded from the state register
    always_comb begin
        tgt_reset_n = 1'b1;
        tgt_sel_n   = 1'b1;
        tgt_wen_n   = 1'b1;
        tgt_cclk    = 1'b1;
        unique case (st)
            S_PULSE, S_INIT_LO: tgt_reset_n = 1'b0;
            S_BYTE, S_CCLK_HI, S_BUSY: begin
                tgt_sel_n = 1'b0;
                tgt_wen_n = 1'b0;
            end
            S_CCLK_LO: begin
                tgt_sel_n = 1'b0;
                tgt_wen_n = 1'b0;
                tgt_cclk  = 1'b0;
            end
            S_CLOSE:   tgt_wen_n = 1'b0;
            default:   ;
        endcase
    end

    // byte counter, data latch and run status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem    <= '0;
            dreg   <= '0;
            ok_q   <= 1'b0;
            fail_q <= 1'b0;
            code_q <= FC_NONE;
        end else begin
            if ((st == S_IDLE) && go) begin
                rem    <= load_len;
                ok_q   <= 1'b0;
                fail_q <= 1'b0;
                code_q <= FC_NONE;
            end
            if (take) begin
                dreg <= s_data;
                rem  <= rem - 1'b1;
            end
            if (fail_set) begin
                fail_q <= 1'b1;
                code_q <= fail_val;
            end
            if (ok_set) ok_q <= 1'b1;
        end
    end

    assign tgt_d     = dreg;
    assign load_ok   = ok_q;
    assign load_fail = fail_q;
    assign fail_code = code_q;

    assert_reset_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_reset_n |-> tgt_sel_n);
    assert_sel_needs_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_sel_n |-> !tgt_wen_n);
    assert_cclk_low_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_cclk |-> !tgt_sel_n);
    assert_data_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tgt_cclk && $past(!tgt_cclk)) |-> $stable(tgt_d));
    assert_data_hold_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_cclk) |-> $stable(tgt_d));
    assert_ready_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (tgt_cclk && !tgt_sel_n && tgt_reset_n));
    assert_wen_after_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel_n && !tgt_wen_n) |=> tgt_wen_n);
    assert_status_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok && load_fail));
    assert_code_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fail |-> (fail_code == 3'd0));
    assert_code_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load_fail |-> (fail_code != 3'd0));
    assert_fail_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_fail) |-> (tgt_reset_n && tgt_sel_n && tgt_wen_n));
endmodule

// File: tb/sim_fpga_cfg_loader.sv
module sim_fpga_cfg_loader;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int P_PROG  = 5;
    localparam int P_PH    = 2;
    localparam int P_INIT  = 40;
    localparam int P_BUSY  = 12;
    localparam int P_DONE  = 30;
    localparam int P_CW    = 8;

    localparam int MI = 0, MP = 1, MWL = 2, MWH = 3, MB = 4, MLO = 5, MHI = 6, MBU = 7, MCL = 8, MFD = 9;

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
    logic [P_CW-1:0] load_len = '0;
    logic s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic tgt_init_n = 1'b1, tgt_done = 1'b0, tgt_busy = 1'b0;
    wire s_ready, tgt_reset_n, tgt_sel_n, tgt_wen_n, tgt_cclk, load_ok, load_fail;
    wire [7:0] tgt_d;
    wire [2:0] fail_code;

    fpga_cfg_loader #(.CNT_W(P_CW), .PROG_CYC(P_PROG), .PHASE_CYC(P_PH), .INIT_TMO(P_INIT),
                      .BUSY_TMO(P_BUSY), .DONE_TMO(P_DONE), .BUSY_CHECK(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .load_len(load_len), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .tgt_reset_n(tgt_reset_n), .tgt_sel_n(tgt_sel_n), .tgt_wen_n(tgt_wen_n),
        .tgt_cclk(tgt_cclk), .tgt_d(tgt_d), .tgt_init_n(tgt_init_n), .tgt_done(tgt_done),
        .tgt_busy(tgt_busy), .load_ok(load_ok), .load_fail(load_fail), .fail_code(fail_code));

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int sc, input int i);
        return 8'(sc * 37 + i * 13 + 5);
    endfunction

    // behavioural reference of the loader pins
    int m_st = MI, m_t = 0, m_rem = 0, m_code = 0;
    logic [7:0] m_d = '0;
    bit m_ok = 0, m_fail = 0;
    bit mi1 = 0, mi2 = 0, md1 = 0, md2 = 0, mb1 = 0, mb2 = 0;

    always @(posedge clk) begin
        int nst;
        if (!rst_n) begin
            m_st = MI; m_t = 0; m_rem = 0; m_code = 0; m_d = '0; m_ok = 0; m_fail = 0;
            mi1 = 0; mi2 = 0; md1 = 0; md2 = 0; mb1 = 0; mb2 = 0;
        end else begin
            nst = m_st;
            case (m_st)
                MI: if (go) begin nst = MP; m_rem = int'(load_len); m_ok = 0; m_fail = 0; m_code = 0; end
                MP: if (m_t == P_PROG - 1) nst = MWL;
                MWL: if (!mi2) nst = MWH;
                     else if (m_t == P_INIT - 1) begin nst = MI; m_fail = 1; m_code = 1; end
                MWH: if (mi2) nst = MB;
                     else if (m_t == P_INIT - 1) begin nst = MI; m_fail = 1; m_code = 2; end
                MB: if (m_rem == 0 || md2) nst = MCL;
                    else if (!mi2) begin nst = MI; m_fail = 1; m_code = 3; end
                    else if (s_valid) begin nst = MLO; m_d = s_data; m_rem--; end
                MLO: if (m_t == P_PH - 1) nst = MHI;
                MHI: if (m_t == P_PH - 1) nst = MBU;
                MBU: if (!mb2) nst = MB;
                     else if (m_t == P_BUSY - 1) begin nst = MI; m_fail = 1; m_code = 4; end
                MCL: nst = MFD;
                MFD: if (md2 && mi2) begin nst = MI; m_ok = 1; end
                     else if (m_t == P_DONE - 1) begin nst = MI; m_fail = 1; m_code = 5; end
                default: nst = MI;
            endcase
            m_t  = (nst == m_st) ? m_t + 1 : 0;
            m_st = nst;
            mi2 = mi1; mi1 = tgt_init_n;
            md2 = md1; md1 = tgt_done;
            mb2 = mb1; mb1 = tgt_busy;
        end
    end

    // emulated target and stream source
    int c_lo, c_hi, c_crc, c_dn, c_bl;
    int lo_cnt = 0, hi_cnt = 0, nbytes = 0, bcnt = 0;
    bit wait_rel = 0, crc_hit = 0, prev_cclk = 1;
    logic [7:0] got [0:31];
    int sc_id = 0, flen = 0, fidx = 0;
    bit gaps = 0, lv = 0, lr = 0;

    always @(negedge clk) begin
        bit sel_on;
        if (rst_n) begin
            sel_on = (m_st == MB || m_st == MLO || m_st == MHI || m_st == MBU);
            chk("R2 reset line", int'(tgt_reset_n), int'(!(m_st == MP || m_st == MWL)));
            chk("R4 select", int'(tgt_sel_n), int'(!sel_on));
            chk("R10 write enable", int'(tgt_wen_n), int'(!(sel_on || m_st == MCL)));
            chk("R5 config clock", int'(tgt_cclk), int'(m_st != MLO));
            chk("R5 data bus", int'(tgt_d), int'(m_d));
            // R11: ready follows the two-stage-delayed status inputs
            chk("R6 R11 ready", int'(s_ready), int'(m_st == MB && m_rem != 0 && !md2 && mi2));
            chk("R10 ok flag", int'(load_ok), int'(m_ok));
            chk("R12 fail flag", int'(load_fail), int'(m_fail));
            chk("R12 fail code", int'(fail_code), m_code);
        end
        if (!tgt_reset_n) begin
            tgt_done = 0; tgt_busy = 0; nbytes = 0; crc_hit = 0; hi_cnt = 0; bcnt = 0;
            if (c_lo >= 0 && lo_cnt >= c_lo) begin tgt_init_n = 0; wait_rel = 1; end
            lo_cnt++;
        end else begin
            lo_cnt = 0;
            if (wait_rel && !crc_hit) begin
                if (c_hi >= 0 && hi_cnt >= c_hi) begin tgt_init_n = 1; wait_rel = 0; end
                hi_cnt++;
            end
            if (bcnt > 0) begin bcnt--; if (bcnt == 0) tgt_busy = 0; end
            if (!prev_cclk && tgt_cclk && !tgt_sel_n && !tgt_wen_n) begin
                if (nbytes < 32) got[nbytes] = tgt_d;
                nbytes++;
                if (nbytes == c_dn) tgt_done = 1;
                if (c_bl > 0) begin tgt_busy = 1; bcnt = c_bl; end
                if (nbytes == c_crc) begin tgt_init_n = 0; crc_hit = 1; end
            end
        end
        prev_cclk = tgt_cclk;
        if (lv && lr) fidx++;
        s_valid = (fidx < flen) && !(gaps && (cyc % 5 == 3));
        s_data  = pat(sc_id, fidx);
        lv = s_valid;
        lr = s_ready;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic run(input int sc, input int len, input int lo, input int hi, input int crc,
                       input int dn, input int bl, input bit gp, input bit mid,
                       input int exp_ok, input int exp_code, input int exp_n, input string tag);
        int n;
        @(posedge clk); #1;
        sc_id = sc; c_lo = lo; c_hi = hi; c_crc = crc; c_dn = dn; c_bl = bl;
        lo_cnt = 0; hi_cnt = 0; wait_rel = 0; crc_hit = 0; nbytes = 0; bcnt = 0;
        fidx = 0; flen = len; gaps = gp; lv = 0; lr = 0;
        load_len = P_CW'(len);
        go = 1'b1;
        @(posedge clk); #1;
        go = 1'b0;
        n = 0;
        while (!(load_ok || load_fail) && n < 3000) begin
            @(posedge clk); #1;
            n++;
            go = (mid && n == 20);   // R1: a start pulse mid-run must be ignored
        end
        go = 1'b0;
        chk({tag, " run finished"}, int'(n < 3000), 1);
        repeat (2) @(posedge clk);
        #1;
        chk({tag, " ok flag"}, int'(load_ok), exp_ok);
        chk({tag, " fail code"}, int'(fail_code), exp_code);
        chk({tag, " bytes at target"}, nbytes, exp_n);
        for (int i = 0; i < exp_n && i < 32; i++)
            chk({tag, " byte value"}, int'(got[i]), int'(pat(sc, i)));
        repeat (3) @(posedge clk);
    endtask

    initial begin
        c_lo = 0; c_hi = 0; c_crc = -1; c_dn = -1; c_bl = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("reset R2 line high", int'(tgt_reset_n), 1);
        chk("reset R4 select high", int'(tgt_sel_n), 1);
        chk("reset R10 wen high", int'(tgt_wen_n), 1);
        chk("reset R5 clock high", int'(tgt_cclk), 1);
        chk("reset R6 not ready", int'(s_ready), 0);
        chk("reset R12 status clear", int'(load_ok) + int'(load_fail) + int'(fail_code), 0);

        run(1, 6, 3, 4, -1, 6, 0, 0, 0, 1, 0, 6, "R1 R5 R6 normal load");
        run(2, 5, 2, 6, -1, 5, 3, 1, 1, 1, 0, 5, "R1 R9 R11 busy gaps and ignored go");
        run(3, 6, 3, 4, -1, 3, 0, 0, 0, 1, 0, 3, "R7 early done");
        run(4, 4, -1, 4, -1, 4, 0, 0, 0, 0, 1, 0, "R2 init never asserts");
        run(5, 4, 2, -1, -1, 4, 0, 0, 0, 0, 2, 0, "R3 init never releases");
        run(6, 6, 2, 3, 2, -1, 0, 0, 0, 0, 3, 2, "R8 init drops mid stream");
        run(7, 4, 2, 3, -1, -1, 1000, 0, 0, 0, 4, 1, "R9 busy stuck");
        run(8, 4, 2, 3, -1, -1, 0, 0, 0, 0, 5, 4, "R10 done never rises");
        run(9, 0, 2, 3, -1, -1, 0, 0, 0, 0, 5, 0, "R10 zero length");
        run(10, 12, 1, 5, -1, 12, 1, 1, 0, 1, 0, 12, "R4 R12 long load after faults");

        summary();
        $finish;
    end
endmodule